// File: doc/BRIEF.md
# NAND Command Intake and Status Unit

This unit is the register front of a NAND flash controller. Software programs a control word holding a run enable and twelve per-source interrupt masks, watches a status word of event flags that it clears by writing ones, and hands over each flash command as three 32-bit words written one after another to a single command-port address. The NAND pin sequencer, ECC logic and DMA engine sit behind the unit. They see the collected command as a one-cycle valid strobe with the three words and the decoded fields of the first word. They report progress back through single-cycle event pulses.

A command is taken only after the unit has raised its command request. This happens when the run enable goes from 0 to 1. The unit then accepts exactly three command-port writes, stores them as words 0, 1 and 2, and releases them to the back end. Command-port writes at any other time are dropped and recorded in a sticky protocol-error flag. Clearing the run enable aborts a partly collected command.

The register offsets are control at 0x00, status at 0x04 and command port at 0x08. Reads are combinational from `addr_i`. The command-port offset reads as zero.

Top module: `nand_cmd_intake`

## Requirements
- R1: After reset the control word reads 0x0000_0FFF (run clear, all twelve sources masked), the status word reads 0, and irq_o and cmd_valid_o are 0.
- R2: A control write that sets bit 28 (run) while run is clear sets status bit 0 (command request), visible in the cycle after the write. A control write with run set while run is already set does not set bit 0 again.
- R3: While a command request is outstanding, three command-port writes are stored in order as words 0, 1 and 2. cmd_words_o carries word k in bits 32k+31:32k. cmd_valid_o is high for exactly one cycle, in the cycle after the third write.
- R4: Word 0 is decoded as follows: cmd_op1_o = bits 7:0, cmd_op2_o = bits 15:8, cmd_naddr_o = bits 18:16, cmd_dbl_o = bit 19, cmd_kind_o = bits 23:21, cmd_cs_o = bit 24.
- R5: A command-port write is dropped, and sets sticky status bit 12 (protocol error), in these cases: run is clear, or no command request is outstanding because the three words were already taken since the last run rise. A dropped write leaves cmd_words_o unchanged and produces no cmd_valid_o.
- R6: A status write clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. Status bits 5 and 6 always read 0.
- R7: A one-cycle back-end pulse sets its flag, visible in the next cycle. The mapping is: read-data request → bit 1, write-data request → bit 2, single-bit error → bit 3, double-bit error → bit 4, command done → bit 8 (be_cs_i=0) or bit 7 (be_cs_i=1), page done → bit 10 (be_cs_i=0) or bit 9 (be_cs_i=1), flash ready → bit 11.
- R8: When an event pulse and a status write clearing the same flag occur in one cycle, the flag ends up set.
- R9: irq_o is a register of the OR over bits 11:0 of (status AND NOT mask). It follows a change in status or mask one cycle later. A mask bit of 1 blocks its source, and bit 12 never raises irq_o.
- R10: Clearing run discards any partly collected words. After the next run rise, collection restarts at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| be_cs_i | input | 1 | Chip select tagging command-done and page-done pulses |
| be_rd_req_i | input | 1 | Back-end read-data request pulse |
| be_wr_req_i | input | 1 | Back-end write-data request pulse |
| be_sbe_i | input | 1 | Single-bit error pulse |
| be_dbe_i | input | 1 | Double-bit error pulse |
| be_cmd_done_i | input | 1 | Command done pulse |
| be_page_done_i | input | 1 | Page done pulse |
| be_ready_i | input | 1 | Flash ready pulse |
| cmd_valid_o | output | 1 | One-cycle strobe: a full command is available |
| cmd_words_o | output | 32*N_WORDS | Collected command words, word 0 in the low bits |
| cmd_op1_o | output | 8 | First opcode from word 0 |
| cmd_op2_o | output | 8 | Second opcode from word 0 |
| cmd_naddr_o | output | 3 | Address-cycle count from word 0 |
| cmd_dbl_o | output | 1 | Two-opcode command flag from word 0 |
| cmd_kind_o | output | 3 | Command type from word 0 |
| cmd_cs_o | output | 1 | Target chip select from word 0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every register write and every back-end pulse takes effect at the clock edge that samples it. Status, control, stored words and cmd_valid_o are therefore visible one cycle after the stimulus. irq_o sits one register further on and is due two cycles after an event pulse, or one cycle after the mask or status register changes. The bench drives on falling edges, reads registers a moment later in the same low phase, and checks irq_o only after one extra falling edge. cmd_valid_o is checked at the falling edge right after the third command write, and again one edge later to confirm the pulse lasted a single cycle.

// File: rtl/nci_pkg.sv
package nci_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned STAT_W = 13;
  localparam int unsigned N_SRC  = 12;
  localparam int unsigned RUN_B  = 28;

  // status bit positions
  localparam int unsigned ST_WCMD   = 0;
  localparam int unsigned ST_RDREQ  = 1;
  localparam int unsigned ST_WRREQ  = 2;
  localparam int unsigned ST_SBE    = 3;
  localparam int unsigned ST_DBE    = 4;
  localparam int unsigned ST_CDONE1 = 7;
  localparam int unsigned ST_CDONE0 = 8;
  localparam int unsigned ST_PDONE1 = 9;
  localparam int unsigned ST_PDONE0 = 10;
  localparam int unsigned ST_RDY    = 11;
  localparam int unsigned ST_PERR   = 12;

  // bits that hold state; 5 and 6 are tied to zero
  localparam logic [STAT_W-1:0] ST_IMPL = 13'h1F9F;

  typedef struct packed {
    logic       cs;
    logic [2:0] kind;
    logic       dbl;
    logic [2:0] naddr;
    logic [7:0] op2;
    logic [7:0] op1;
  } cmd_fields_t;
endpackage

// File: rtl/nci_ctrl_reg.sv
module nci_ctrl_reg
  import nci_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             run_d_i,
  input  logic [N_SRC-1:0] mask_d_i,
  output logic             run_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             run_rise_o,
  output logic             run_fall_o
);
  logic             run_q;
  logic [N_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mask_q <= '1;
    end else if (we_i) begin
      run_q  <= run_d_i;
      mask_q <= mask_d_i;
    end
  end

  assign run_rise_o = we_i &&  run_d_i && !run_q;
  assign run_fall_o = we_i && !run_d_i &&  run_q;
  assign run_o      = run_q;
  assign mask_o     = mask_q;
endmodule

// File: rtl/nci_status_reg.sv
module nci_status_reg
  import nci_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  // set has priority over a write-one clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~clr_i) | set_i) & ST_IMPL;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/nci_cmd_collect.sv
module nci_cmd_collect #(
  parameter int unsigned N_WORDS = 3,
  parameter int unsigned DW      = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_rise_i,
  input  logic                        run_fall_i,
  input  logic                        we_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [N_WORDS-1:0][DW-1:0]  words_o,
  output logic                        valid_o,
  output logic                        drop_o
);
  localparam int unsigned CNT_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_WORDS - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic             take;

  assign take   = we_i && armed_q;
  assign drop_o = we_i && !armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (run_rise_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (run_fall_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (take) begin
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          word_q <= '0;
      else if (take && cnt_q == CNT_W'(g))  word_q <= wdata_i;
    end
    assign words_o[g] = word_q;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/nci_cmd_decode.sv
module nci_cmd_decode
  import nci_pkg::*;
(
  // word 0 with bit 20 removed: {w0[24:21], w0[19:0]}
  input  logic [23:0]  w0_i,
  output cmd_fields_t  fields_o
);
  always_comb begin
    fields_o.op1   = w0_i[7:0];
    fields_o.op2   = w0_i[15:8];
    fields_o.naddr = w0_i[18:16];
    fields_o.dbl   = w0_i[19];
    fields_o.kind  = w0_i[22:20];
    fields_o.cs    = w0_i[23];
  end
endmodule

// File: rtl/nand_cmd_intake.sv
module nand_cmd_intake
  import nci_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N_WORDS  = 3,
  parameter int unsigned CTRL_OFF = 'h00,
  parameter int unsigned STAT_OFF = 'h04,
  parameter int unsigned CMD_OFF  = 'h08
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic                  be_cs_i,
  input  logic                  be_rd_req_i,
  input  logic                  be_wr_req_i,
  input  logic                  be_sbe_i,
  input  logic                  be_dbe_i,
  input  logic                  be_cmd_done_i,
  input  logic                  be_page_done_i,
  input  logic                  be_ready_i,
  output logic                  cmd_valid_o,
  output logic [32*N_WORDS-1:0] cmd_words_o,
  output logic [7:0]            cmd_op1_o,
  output logic [7:0]            cmd_op2_o,
  output logic [2:0]            cmd_naddr_o,
  output logic                  cmd_dbl_o,
  output logic [2:0]            cmd_kind_o,
  output logic                  cmd_cs_o,
  output logic                  irq_o
);
  logic ctrl_we, stat_we, cmd_we;
  assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(CTRL_OFF));
  assign stat_we = wr_en_i && (addr_i == ADDR_W'(STAT_OFF));
  assign cmd_we  = wr_en_i && (addr_i == ADDR_W'(CMD_OFF));

  logic             run_q, run_rise, run_fall;
  logic [N_SRC-1:0] mask_q;

  nci_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we),
    .run_d_i    (wdata_i[RUN_B]),
    .mask_d_i   (wdata_i[N_SRC-1:0]),
    .run_o      (run_q),
    .mask_o     (mask_q),
    .run_rise_o (run_rise),
    .run_fall_o (run_fall)
  );

  logic [N_WORDS-1:0][DW-1:0] words;
  logic                       cmd_drop;

  nci_cmd_collect #(.N_WORDS(N_WORDS), .DW(DW)) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_rise_i (run_rise),
    .run_fall_i (run_fall),
    .we_i       (cmd_we),
    .wdata_i    (wdata_i),
    .words_o    (words),
    .valid_o    (cmd_valid_o),
    .drop_o     (cmd_drop)
  );

  logic [STAT_W-1:0] stat_set, stat_clr, stat_q;

  always_comb begin
    stat_set            = '0;
    stat_set[ST_WCMD]   = run_rise;
    stat_set[ST_RDREQ]  = be_rd_req_i;
    stat_set[ST_WRREQ]  = be_wr_req_i;
    stat_set[ST_SBE]    = be_sbe_i;
    stat_set[ST_DBE]    = be_dbe_i;
    stat_set[ST_CDONE0] = be_cmd_done_i  && !be_cs_i;
    stat_set[ST_CDONE1] = be_cmd_done_i  &&  be_cs_i;
    stat_set[ST_PDONE0] = be_page_done_i && !be_cs_i;
    stat_set[ST_PDONE1] = be_page_done_i &&  be_cs_i;
    stat_set[ST_RDY]    = be_ready_i;
    stat_set[ST_PERR]   = cmd_drop;
  end

  assign stat_clr = stat_we ? wdata_i[STAT_W-1:0] : '0;

  nci_status_reg u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stat_set),
    .clr_i  (stat_clr),
    .stat_o (stat_q)
  );

  cmd_fields_t fields;

  nci_cmd_decode u_decode (
    .w0_i     ({words[0][24:21], words[0][19:0]}),
    .fields_o (fields)
  );

  assign cmd_words_o = words;
  assign cmd_op1_o   = fields.op1;
  assign cmd_op2_o   = fields.op2;
  assign cmd_naddr_o = fields.naddr;
  assign cmd_dbl_o   = fields.dbl;
  assign cmd_kind_o  = fields.kind;
  assign cmd_cs_o    = fields.cs;

  // protocol-error bit is outside the interrupt sources
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_q[N_SRC-1:0] & ~mask_q);
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_OFF)) begin
      rdata_o[RUN_B]     = run_q;
      rdata_o[N_SRC-1:0] = mask_q;
    end else if (addr_i == ADDR_W'(STAT_OFF)) begin
      rdata_o[STAT_W-1:0] = stat_q;
    end
  end
endmodule

// File: rtl/nci_checker.sv
module nci_checker
  import nci_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stat_we,
  input logic [STAT_W-1:0] wdata_lo,
  input logic              run,
  input logic [STAT_W-1:0] stat,
  input logic [N_SRC-1:0]  mask,
  input logic              irq,
  input logic              cmd_valid,
  input logic              ready_ev
);
  a_r2_rise_raises_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> stat[ST_WCMD]);

  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid |=> !cmd_valid);

  a_r3_valid_while_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid |-> run);

  a_r5_perr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[ST_PERR] && !(stat_we && wdata_lo[ST_PERR])) |=> stat[ST_PERR]);

  a_r6_w1c_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && wdata_lo[ST_RDY] && !ready_ev) |=> !stat[ST_RDY]);

  a_r6_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat[6:5] == 2'b00);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_ev |=> stat[ST_RDY]);

  a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat[N_SRC-1:0] & ~mask) == '0) |=> !irq);

  a_r9_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat[N_SRC-1:0] & ~mask) != '0) |=> irq);
endmodule

bind nand_cmd_intake nci_checker u_nci_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stat_we   (stat_we),
  .wdata_lo  (wdata_i[12:0]),
  .run       (run_q),
  .stat      (stat_q),
  .mask      (mask_q),
  .irq       (irq_o),
  .cmd_valid (cmd_valid_o),
  .ready_ev  (be_ready_i)
);

// File: tb/nand_cmd_intake_bench.sv
module nand_cmd_intake_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_CMD  = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic be_cs = 0, be_rd = 0, be_wr = 0, be_sbe = 0, be_dbe = 0;
  logic be_cdone = 0, be_pdone = 0, be_rdy = 0;
  logic        cmd_valid;
  logic [95:0] cmd_words;
  logic [7:0]  op1, op2;
  logic [2:0]  naddr, kind;
  logic        dbl, ccs, irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_intake u_nand_cmd_intake (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .be_cs_i(be_cs),
    .be_rd_req_i(be_rd), .be_wr_req_i(be_wr), .be_sbe_i(be_sbe),
    .be_dbe_i(be_dbe), .be_cmd_done_i(be_cdone), .be_page_done_i(be_pdone),
    .be_ready_i(be_rdy), .cmd_valid_o(cmd_valid), .cmd_words_o(cmd_words),
    .cmd_op1_o(op1), .cmd_op2_o(op2), .cmd_naddr_o(naddr), .cmd_dbl_o(dbl),
    .cmd_kind_o(kind), .cmd_cs_o(ccs), .irq_o(irq)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input int which, input logic cs);
    @(negedge clk);
    be_cs = cs;
    case (which)
      1: be_rd = 1'b1;
      2: be_wr = 1'b1;
      3: be_sbe = 1'b1;
      4: be_dbe = 1'b1;
      5: be_cdone = 1'b1;
      6: be_pdone = 1'b1;
      default: be_rdy = 1'b1;
    endcase
    @(negedge clk);
    {be_rd, be_wr, be_sbe, be_dbe, be_cdone, be_pdone, be_rdy} = '0;
    be_cs = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0000_0FFF);
    rd(A_STAT, d); check("R1 stat", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 cmd_valid", {31'b0, cmd_valid}, 32'h0);
  endtask

  task automatic t_run_start();
    logic [31:0] d;
    wr(A_CTRL, 32'h1000_0000);
    rd(A_STAT, d); check("R2 req on rise", d, 32'h1);
    rd(A_CTRL, d); check("R2 ctrl run", d, 32'h1000_0000);
    wr(A_STAT, 32'h1);
    wr(A_CTRL, 32'h1000_0000);
    rd(A_STAT, d); check("R2 no req when run held", d, 32'h0);
  endtask

  task automatic t_cmd();
    wr(A_CMD, 32'h0164_8030);
    wr(A_CMD, 32'h1234_5678);
    check("R3 no valid before third", {31'b0, cmd_valid}, 32'h0);
    wr(A_CMD, 32'h0000_009A);
    check("R3 valid after third", {31'b0, cmd_valid}, 32'h1);
    check("R3 word0", cmd_words[31:0],  32'h0164_8030);
    check("R3 word1", cmd_words[63:32], 32'h1234_5678);
    check("R3 word2", cmd_words[95:64], 32'h0000_009A);
    check("R4 op1",   {24'b0, op1}, 32'h30);
    check("R4 op2",   {24'b0, op2}, 32'h80);
    check("R4 naddr", {29'b0, naddr}, 32'h4);
    check("R4 dbl",   {31'b0, dbl}, 32'h0);
    check("R4 kind",  {29'b0, kind}, 32'h3);
    check("R4 cs",    {31'b0, ccs}, 32'h1);
    @(negedge clk);
    check("R3 valid one cycle", {31'b0, cmd_valid}, 32'h0);
  endtask

  task automatic t_drop_after();
    logic [31:0] d;
    wr(A_CMD, 32'h0000_DEAD);
    check("R5 no valid on extra write", {31'b0, cmd_valid}, 32'h0);
    check("R5 word0 kept", cmd_words[31:0], 32'h0164_8030);
    rd(A_STAT, d); check("R5 perr after extra", d, 32'h1000);
    wr(A_STAT, 32'h1000);
    rd(A_STAT, d); check("R6 perr cleared", d, 32'h0);
  endtask

  task automatic t_stop_restart();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1000_0000);
    wr(A_CMD, 32'h0000_AAAA);
    wr(A_CMD, 32'h0000_BBBB);
    wr(A_CTRL, 32'h0);
    wr(A_CMD, 32'h0000_CCCC);
    check("R10 no valid after stop", {31'b0, cmd_valid}, 32'h0);
    rd(A_STAT, d); check("R5 drop while stopped", d, 32'h1001);
    wr(A_STAT, 32'h1FFF);
    wr(A_CTRL, 32'h1000_0000);
    wr(A_CMD, 32'h0011_0001);
    wr(A_CMD, 32'h0000_2222);
    wr(A_CMD, 32'h0000_3333);
    check("R10 valid after restart", {31'b0, cmd_valid}, 32'h1);
    check("R10 word0 fresh", cmd_words[31:0],  32'h0011_0001);
    check("R10 word1 fresh", cmd_words[63:32], 32'h0000_2222);
    check("R10 word2 fresh", cmd_words[95:64], 32'h0000_3333);
    wr(A_STAT, 32'h1FFF);
  endtask

  task automatic t_events();
    logic [31:0] d;
    int          which [9] = '{1, 2, 3, 4, 5, 5, 6, 6, 7};
    logic        cs    [9] = '{0, 0, 0, 0, 0, 1, 0, 1, 0};
    logic [31:0] exp   [9] = '{32'h002, 32'h004, 32'h008, 32'h010,
                               32'h100, 32'h080, 32'h400, 32'h200, 32'h800};
    for (int i = 0; i < 9; i++) begin
      pulse(which[i], cs[i]);
      rd(A_STAT, d); check("R7 event flag", d, exp[i]);
      wr(A_STAT, 32'hFFF);
    end
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(7, 1'b0);
    pulse(3, 1'b0);
    rd(A_STAT, d); check("R6 two flags", d, 32'h808);
    wr(A_STAT, 32'h008);
    rd(A_STAT, d); check("R6 clear one", d, 32'h800);
    wr(A_STAT, 32'h000);
    rd(A_STAT, d); check("R6 zero write no effect", d, 32'h800);
    wr(A_STAT, 32'h060);
    rd(A_STAT, d); check("R6 spare bits stay zero", d, 32'h800);
    wr(A_STAT, 32'h800);
    rd(A_STAT, d); check("R6 cleared", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    be_rdy = 1'b1; wr_en = 1'b1; addr = A_STAT; wdata = 32'h800;
    @(negedge clk);
    be_rdy = 1'b0; wr_en = 1'b0;
    rd(A_STAT, d); check("R8 set beats clear", d, 32'h800);
    wr(A_STAT, 32'h800);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_CTRL, 32'h1000_0FFF);
    wr(A_STAT, 32'h1FFF);
    pulse(3, 1'b0);
    @(negedge clk);
    check("R9 masked source quiet", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h1000_0FF7);
    rd(A_CTRL, d); check("R9 mask readback", d, 32'h1000_0FF7);
    @(negedge clk);
    check("R9 unmasked source raises", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h008);
    @(negedge clk);
    check("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h1000_0000);
    wr(A_CMD, 32'h0000_0055);
    rd(A_STAT, d); check("R5 perr with run held", d, 32'h1000);
    @(negedge clk);
    @(negedge clk);
    check("R9 perr excluded from irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_start();
    t_cmd();
    t_drop_after();
    t_stop_restart();
    t_events();
    t_w1c();
    t_set_wins();
    t_irq();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule